// File: doc/BRIEF.md
# Quadrature Phase-Counting Timer Channel

This block is a 16-bit timer channel with two counting personalities. In normal mode the counter advances by one on a chosen count source. That source is either an internal enable pulse or an edge of external input A, with a choice of rising, falling or both edges. In phase mode the two external inputs A and B are read as a quadrature pair. Every edge on either input moves the counter one step up or down, so one full quadrature cycle gives four counts. In phase mode the source and edge selection are ignored.

Both inputs pass through a two-stage synchronizer before edges are detected. A cycle in which A and B both change is treated as an illegal transition and leaves the count alone. An overflow flag catches wrap-around. A mode bit decides whether a downward wrap also raises it. The flag stays set until software reads it as 1 and then writes 0 to it. The clear request and the compare-match output work the same way in both modes. Software reaches the mode, source, counter, compare and status registers through a simple register bus. A read returns data combinationally for the address on the bus. A write takes effect at the clock edge.

Top module: `quad_timer`

## Requirements
- R1: After reset the mode register reads 0x00B8 (phase mode off, flag-direction bit 5 = 1, reserved bits 7, 4 and 3 = 1), the counter is 0, the overflow flag is 0 and the compare register holds 0xFFFF. Register addresses: 0 mode, 1 source, 2 counter, 3 compare, 4 status (bit 0 = overflow flag).
- R2: Mode bits 7, 4 and 3 always read 1 and bits 2..0 always read 0, whatever is written. Only bit 6 (phase mode) and bit 5 (flag direction) are writable.
- R3: In phase mode the counter steps up when B rises with A low, A rises with B high, B falls with A high, or A falls with B low. An input change written before clock edge k shows in the counter after edge k+2.
- R4: In phase mode the counter steps down when A rises with B low, B rises with A high, A falls with B high, or B falls with A low.
- R5: A cycle in which the synchronized A and B both change leaves the counter unchanged.
- R6: In phase mode the source register and the internal enable input have no effect on the count.
- R7: In normal mode the counter increments once per event of the source chosen by source register bits 1:0: 0 = internal enable high in that cycle, 1 = A rising edge, 2 = A falling edge, 3 = either A edge. The A edges pass through the same synchronizer delay as in R3.
- R8: A step up from 0xFFFF to 0x0000 sets the overflow flag in every mode.
- R9: A step down from 0x0000 to 0xFFFF sets the overflow flag only when mode bit 5 is 0.
- R10: The overflow flag stays set. Writing 0 to status bit 0 clears it only when the status register has been read with the flag at 1 since the last status write.
- R11: A software write to the counter loads the written value and takes priority over a counting event in the same cycle.
- R12: A pulse on the clear request makes the next counting event load 0 in place of the step, in either mode, and raises no overflow.
- R13: The compare-match output is high exactly while the counter equals the compare register, in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms the flag clear) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| in_a | input | 1 | External input A, asynchronous |
| in_b | input | 1 | External input B, asynchronous |
| tick_int | input | 1 | Internal count-enable pulse |
| clr_req | input | 1 | Counter clear request |
| cnt_q | output | 16 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_match | output | 1 | Counter equals compare register |

## Verification
A wrong step direction or a missed edge in the quadrature decoder leaves cnt_q off by one. This shows two clock edges after the input change that caused it. The error then persists, so a reference model compared on every clock finds it at the first mismatch. A lost clear request, a bad flag-direction decision or a broken read-then-write clear sequence shows on ovf_flag or cnt_q at the next counting event or status write. A stale compare register shows on cmp_match as soon as the counter passes the compare value.

// File: rtl/qt_pkg.sv
// Shared types for the quadrature timer channel.
// Assumes a 3-bit register address space.
package qt_pkg;
    typedef enum logic [2:0] {
        REG_MODE = 3'd0,
        REG_SRC  = 3'd1,
        REG_CNT  = 3'd2,
        REG_CMP  = 3'd3,
        REG_STAT = 3'd4
    } qt_reg_e;

    typedef enum logic [1:0] {
        SRC_TICK   = 2'd0,
        SRC_A_RISE = 2'd1,
        SRC_A_FALL = 2'd2,
        SRC_A_BOTH = 2'd3
    } qt_src_e;
endpackage

// File: rtl/qt_sync.sv
// Multi-stage synchronizer for one asynchronous input.
// Also keeps the previous synchronized sample, for edge detection.
// Assumes STAGES >= 2. Both outputs reset to 0.
module qt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic q_prev
);
    logic [STAGES:0] sr;

    // Shift the raw input through the synchronizer and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-1:0], d};
    end

    assign q      = sr[STAGES-1];
    assign q_prev = sr[STAGES];
endmodule

// File: rtl/qt_phase_dec.sv
// Quadrature decoder: turns the current and previous synchronized A/B
// samples into a one-cycle up or down step. A cycle where both inputs
// changed is illegal and yields no step.
// Assumes inputs are already synchronous to clk.
module qt_phase_dec (
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic a_prev,
    input  logic b,
    input  logic b_prev,
    output logic up,
    output logic dn
);
    logic a_rise, a_fall, b_rise, b_fall, both_chg;

    // Edge and illegal-transition detection.
    always_comb begin
        a_rise   = a & ~a_prev;
        a_fall   = ~a & a_prev;
        b_rise   = b & ~b_prev;
        b_fall   = ~b & b_prev;
        both_chg = (a ^ a_prev) & (b ^ b_prev);
    end

    // Direction decision from the level of the input that did not move.
    always_comb begin
        up = ~both_chg & ((b_rise & ~a) | (a_rise & b) | (b_fall & a) | (a_fall & ~b));
        dn = ~both_chg & ((a_rise & ~b) | (b_rise & a) | (a_fall & b) | (b_fall & ~a));
    end

    p_one_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({up, dn}));
    p_illegal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((a != a_prev) && (b != b_prev)) |-> (!up && !dn));
endmodule

// File: rtl/qt_counter.sv
// Up/down counter with software load and a pending clear request.
// Reports wrap in both directions for the flag logic.
// Assumes up and dn are never high together.
module qt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up,
    input  logic         dn,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         clr_req,
    output logic [W-1:0] cnt,
    output logic         wrap_up,
    output logic         wrap_dn
);
    logic pend;
    logic clr_now;
    logic evt;

    // The clear takes effect at the current event or the next one.
    always_comb begin
        clr_now = pend | clr_req;
        evt     = up | dn;
        wrap_up = up & ~wr_en & ~clr_now & (cnt == {W{1'b1}});
        wrap_dn = dn & ~wr_en & ~clr_now & (cnt == '0);
    end

    // Counter state: a write wins, then a clear-on-event, then a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else if (wr_en) begin
            cnt  <= wr_val;
            pend <= clr_now;
        end else if (evt) begin
            cnt  <= clr_now ? '0 : (up ? cnt + 1'b1 : cnt - 1'b1);
            pend <= 1'b0;
        end else begin
            pend <= clr_now;
        end
    end

    p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (up && !wr_en && !clr_now) |=> (cnt == $past(cnt) + 1'b1));
    p_step_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dn && !wr_en && !clr_now) |=> (cnt == $past(cnt) - 1'b1));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!up && !dn && !wr_en) |=> $stable(cnt));
    p_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt == $past(wr_val)));
    p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((up || dn) && clr_now && !wr_en) |=> (cnt == '0));
endmodule

// File: rtl/quad_timer.sv
// Quadrature phase-counting timer channel, top level.
// Holds the mode, source, compare and status registers. Selects the
// count source (normal or phase mode) and keeps the sticky overflow flag.
// Assumes a bus read returns data combinationally and a write lands at
// the clock edge. in_a and in_b are asynchronous.
module quad_timer
    import qt_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   bus_addr,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         in_a,
    input  logic         in_b,
    input  logic         tick_int,
    input  logic         clr_req,
    output logic [W-1:0] cnt_q,
    output logic         ovf_flag,
    output logic         cmp_match
);
    localparam int NIN = 2;

    logic           phase_q, fdir_q, ovf_q, arm_q;
    qt_src_e        src_q;
    logic [W-1:0]   cmp_q;
    logic [NIN-1:0] raw, s_cur, s_prev;
    logic           pd_up, pd_dn, norm_evt, up, dn;
    logic           wrap_up, wrap_dn;
    logic           wr_mode, wr_src, wr_cnt, wr_cmp, wr_stat, rd_stat;

    assign raw = {in_b, in_a};

    // One synchronizer per external input.
    for (genvar i = 0; i < NIN; i++) begin : g_sync
        qt_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .d      (raw[i]),
            .q      (s_cur[i]),
            .q_prev (s_prev[i])
        );
    end

    qt_phase_dec u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .a      (s_cur[0]),
        .a_prev (s_prev[0]),
        .b      (s_cur[1]),
        .b_prev (s_prev[1]),
        .up     (pd_up),
        .dn     (pd_dn)
    );

    // Normal-mode event from the selected source.
    always_comb begin
        unique case (src_q)
            SRC_TICK:   norm_evt = tick_int;
            SRC_A_RISE: norm_evt = s_cur[0] & ~s_prev[0];
            SRC_A_FALL: norm_evt = ~s_cur[0] & s_prev[0];
            default:    norm_evt = s_cur[0] ^ s_prev[0];
        endcase
    end

    // Phase mode overrides the normal source completely.
    always_comb begin
        up = phase_q ? pd_up : norm_evt;
        dn = phase_q & pd_dn;
    end

    // Register access decode.
    always_comb begin
        wr_mode = bus_wr && (bus_addr == REG_MODE);
        wr_src  = bus_wr && (bus_addr == REG_SRC);
        wr_cnt  = bus_wr && (bus_addr == REG_CNT);
        wr_cmp  = bus_wr && (bus_addr == REG_CMP);
        wr_stat = bus_wr && (bus_addr == REG_STAT);
        rd_stat = bus_rd && (bus_addr == REG_STAT);
    end

    qt_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .up      (up),
        .dn      (dn),
        .wr_en   (wr_cnt),
        .wr_val  (bus_wdata),
        .clr_req (clr_req),
        .cnt     (cnt_q),
        .wrap_up (wrap_up),
        .wrap_dn (wrap_dn)
    );

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            fdir_q  <= 1'b1;
            src_q   <= SRC_TICK;
            cmp_q   <= '1;
        end else begin
            if (wr_mode) begin
                phase_q <= bus_wdata[6];
                fdir_q  <= bus_wdata[5];
            end
            if (wr_src) src_q <= qt_src_e'(bus_wdata[1:0]);
            if (wr_cmp) cmp_q <= bus_wdata;
        end
    end

    // Sticky overflow flag with read-then-write-zero clear; a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            arm_q <= 1'b0;
        end else begin
            if (wrap_up || (wrap_dn && !fdir_q))
                ovf_q <= 1'b1;
            else if (wr_stat && arm_q && !bus_wdata[0])
                ovf_q <= 1'b0;
            if (wr_stat)
                arm_q <= 1'b0;
            else if (rd_stat && ovf_q)
                arm_q <= 1'b1;
        end
    end

    // Read data mux; reserved mode bits read as 1.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_MODE: bus_rdata[7:0] = {1'b1, phase_q, fdir_q, 2'b11, 3'b000};
            REG_SRC:  bus_rdata[1:0] = src_q;
            REG_CNT:  bus_rdata      = cnt_q;
            REG_CMP:  bus_rdata      = cmp_q;
            REG_STAT: bus_rdata[0]   = ovf_q;
            default:  bus_rdata      = '0;
        endcase
    end

    assign ovf_flag  = ovf_q;
    assign cmp_match = (cnt_q == cmp_q);

    p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_up |=> ovf_flag);
    p_udf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_dn && !fdir_q) |=> ovf_flag);
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !wr_stat) |=> ovf_flag);
    p_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q && !pd_up && !pd_dn && !wr_cnt) |=> $stable(cnt_q));
endmodule

// File: tb/test_quad_timer.sv
module test_quad_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        in_a = 1'b0, in_b = 1'b0, tick_int = 1'b0, clr_req = 1'b0;
    logic [15:0] cnt_q;
    logic        ovf_flag, cmp_match;

    int checks = 0, failures = 0;
    bit live = 1'b0, done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_cnt, m_cmp;
    bit m_phase, m_fdir, m_ovf, m_arm, m_pend;
    int m_src;
    bit ha[$], hb[$];
    bit qa = 0, qb = 0;

    always #10 clk = ~clk;

    quad_timer i_quad_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_a(in_a), .in_b(in_b), .tick_int(tick_int), .clr_req(clr_req),
        .cnt_q(cnt_q), .ovf_flag(ovf_flag), .cmp_match(cmp_match)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural model updated at each clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_cmp = 16'hFFFF; m_phase = 0; m_fdir = 1;
            m_ovf = 0; m_arm = 0; m_pend = 0; m_src = 0;
            ha = '{0, 0, 0}; hb = '{0, 0, 0};
        end else begin
            bit a1, a2, b1, b2, stepu, stepd, clrnow, setf;
            a1 = ha[1]; a2 = ha[2]; b1 = hb[1]; b2 = hb[2];
            stepu = 0; stepd = 0; setf = 0;
            if (m_phase) begin
                if (a1 != a2 && b1 != b2) ;
                else if (a1 != a2) begin
                    if (a1 == b1) stepu = 1; else stepd = 1;
                end else if (b1 != b2) begin
                    if (b1 != a1) stepu = 1; else stepd = 1;
                end
            end else begin
                case (m_src)
                    0: stepu = tick_int;
                    1: stepu = a1 && !a2;
                    2: stepu = !a1 && a2;
                    default: stepu = a1 != a2;
                endcase
            end
            clrnow = m_pend || clr_req;
            if (bus_wr && bus_addr == 2) begin
                m_cnt = bus_wdata; m_pend = clrnow;
            end else if (stepu || stepd) begin
                if (clrnow) m_cnt = 0;
                else if (stepu) begin
                    if (m_cnt == 16'hFFFF) setf = 1;
                    m_cnt = (m_cnt + 1) & 16'hFFFF;
                end else begin
                    if (m_cnt == 0 && !m_fdir) setf = 1;
                    m_cnt = (m_cnt - 1) & 16'hFFFF;
                end
                m_pend = 0;
            end else m_pend = clrnow;
            if (setf) m_ovf = 1;
            else if (bus_wr && bus_addr == 4 && m_arm && !bus_wdata[0]) m_ovf = 0;
            if (bus_wr && bus_addr == 4) m_arm = 0;
            else if (bus_rd && bus_addr == 4 && m_ovf && !setf) m_arm = 1;
            else if (bus_rd && bus_addr == 4 && setf) m_arm = m_arm || (m_ovf && 1'b0);
            if (bus_wr && bus_addr == 0) begin m_phase = bus_wdata[6]; m_fdir = bus_wdata[5]; end
            if (bus_wr && bus_addr == 1) m_src = bus_wdata[1:0];
            if (bus_wr && bus_addr == 3) m_cmp = bus_wdata;
            ha.push_front(in_a); void'(ha.pop_back());
            hb.push_front(in_b); void'(hb.pop_back());
        end
    end

    // Compare the ports with the model on every clock.
    always @(negedge clk) begin
        if (live && rst_n) begin
            check(cur_req, "cnt_q", cnt_q, m_cnt);
            check(cur_req, "ovf_flag", ovf_flag, m_ovf);
            check("R13", "cmp_match", cmp_match, (m_cnt == m_cmp));
        end
    end

    task automatic wr(int addr, int data);
        @(negedge clk); bus_addr = 3'(addr); bus_wdata = 16'(data); bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(int addr, output int data);
        @(negedge clk); bus_addr = 3'(addr); bus_rd = 1; #2 data = bus_rdata;
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ab(bit a, bit b);
        @(negedge clk); in_a = a; in_b = b; qa = a; qb = b;
        settle(4);
    endtask

    // forward quadrature order 00 -> 01 -> 11 -> 10 (written {A,B})
    task automatic q_fwd();
        case ({qa, qb})
            2'b00: set_ab(0, 1);
            2'b01: set_ab(1, 1);
            2'b11: set_ab(1, 0);
            default: set_ab(0, 0);
        endcase
    endtask

    task automatic q_rev();
        case ({qa, qb})
            2'b00: set_ab(1, 0);
            2'b10: set_ab(1, 1);
            2'b11: set_ab(0, 1);
            default: set_ab(0, 0);
        endcase
    endtask

    task automatic pulse_tick(int n);
        repeat (n) begin
            @(negedge clk); tick_int = 1;
            @(negedge clk); tick_int = 0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v;
        settle(3);
        @(negedge clk); rst_n = 1; live = 1;
        settle(1);
        // R1 reset state
        rd(0, v); check("R1", "mode reset", v, 16'h00B8);
        check("R1", "cnt reset", cnt_q, 0);
        rd(3, v); check("R1", "cmp reset", v, 16'hFFFF);
        check("R1", "ovf reset", ovf_flag, 0);
        // R2 reserved bits
        cur_req = "R2";
        wr(0, 16'h0000); rd(0, v); check("R2", "mode after 0", v, 16'h0098);
        wr(0, 16'hFFFF); rd(0, v); check("R2", "mode after FFFF", v, 16'h00F8);
        // R7 normal mode sources
        cur_req = "R7";
        wr(0, 16'h0020); wr(1, 0);
        pulse_tick(5); settle(2);
        check("R7", "tick count", cnt_q, 5);
        wr(1, 1);
        set_ab(1, 0); set_ab(0, 0); set_ab(1, 0); set_ab(0, 0);
        check("R7", "A rising count", cnt_q, 7);
        wr(1, 2);
        set_ab(1, 0); set_ab(0, 0);
        check("R7", "A falling count", cnt_q, 8);
        wr(1, 3);
        set_ab(1, 0); set_ab(0, 0);
        check("R7", "A both count", cnt_q, 10);
        // R11 write wins over a tick in the same cycle
        cur_req = "R11";
        wr(1, 0);
        @(negedge clk); bus_addr = 3'd2; bus_wdata = 16'h1234; bus_wr = 1; tick_int = 1;
        @(negedge clk); bus_wr = 0; tick_int = 0;
        check("R11", "write priority", cnt_q, 16'h1234);
        // R3 phase up
        cur_req = "R3";
        wr(2, 0); wr(0, 16'h0060);
        repeat (8) q_fwd();
        check("R3", "eight up steps", cnt_q, 8);
        // R4 phase down
        cur_req = "R4";
        repeat (8) q_rev();
        check("R4", "eight down steps", cnt_q, 0);
        // R5 both inputs change together
        cur_req = "R5";
        set_ab(1, 1); set_ab(0, 0);
        check("R5", "illegal transition", cnt_q, 0);
        // R6 source and tick ignored in phase mode
        cur_req = "R6";
        wr(1, 3); pulse_tick(3);
        check("R6", "tick ignored", cnt_q, 0);
        q_fwd();
        check("R6", "single step", cnt_q, 1);
        q_rev();
        // R9 underflow with flag direction 1: no flag
        cur_req = "R9";
        q_rev();
        check("R9", "underflow cnt", cnt_q, 16'hFFFF);
        check("R9", "no flag when bit5=1", ovf_flag, 0);
        // R8 overflow
        cur_req = "R8";
        q_fwd();
        check("R8", "overflow cnt", cnt_q, 0);
        check("R8", "flag on overflow", ovf_flag, 1);
        // R10 sticky and read-then-clear
        cur_req = "R10";
        wr(4, 0); settle(1);
        check("R10", "write without read", ovf_flag, 1);
        rd(4, v); check("R10", "status read", v, 1);
        wr(4, 0); settle(1);
        check("R10", "cleared after read", ovf_flag, 0);
        // R9 underflow with flag direction 0
        cur_req = "R9";
        wr(0, 16'h0040);
        q_rev();
        check("R9", "flag on underflow", ovf_flag, 1);
        rd(4, v); wr(4, 0);
        // R12 clear request in phase mode
        cur_req = "R12";
        wr(2, 16'h0010);
        @(negedge clk); clr_req = 1; @(negedge clk); clr_req = 0;
        settle(3);
        check("R12", "clear waits for event", cnt_q, 16'h0010);
        q_fwd();
        check("R12", "clear on phase event", cnt_q, 0);
        // R12 clear request in normal mode
        wr(0, 16'h0020); wr(1, 0); wr(2, 16'h0009);
        @(negedge clk); clr_req = 1; @(negedge clk); clr_req = 0;
        pulse_tick(1); settle(1);
        check("R12", "clear on tick", cnt_q, 0);
        // R13 compare match in both modes
        cur_req = "R13";
        wr(3, 5); wr(2, 4); settle(1);
        check("R13", "no match at 4", cmp_match, 0);
        pulse_tick(1); settle(1);
        check("R13", "match at 5", cmp_match, 1);
        wr(0, 16'h0060);
        q_fwd();
        check("R13", "no match at 6", cmp_match, 0);
        q_rev();
        check("R13", "phase match at 5", cmp_match, 1);
        settle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule